// File: doc/BRIEF.md
# Configuration Command Transaction Controller

The block sits on a simple 32-bit register bus and gives software three registers: a command word, a data word and a status word. Software puts an operand in the data word, then writes the command word with its launch bit set. In that same cycle the block splits the command into its fields and checks them against the supported set of targets. It then carries out one read or one write against a modelled configuration space.

The modelled space has three parts. The first is a bank of oscillator frequency settings: six on the main board and a parameterised number on the daughter board. The second is a set of voltage sensors, where the main board always reports a fixed 3.3 V value and the daughter board reads from a parameter table. The third is a small group of write-only control functions. Two of these raise single-cycle power-off and restart request pulses. Every launch leaves a done flag and, when the access is not supported, an error flag in the status word. A successful read places its result in the data word.

Top module: `cfg_cmd_ctrl`

## Requirements
- R1: After reset the command, data and status words read zero and both request outputs are low. The six main-board oscillators hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughter-board oscillator k holds entry k of the DB_OSC_INIT parameter.
- R2: The command word has these fields: bit 31 launch, bit 30 direction (1 write, 0 read), bits 29:26 dcc, bits 25:20 function code, bits 17:16 site, bits 15:12 position, bits 11:0 device. It stores every written bit except 31, 19 and 18, which always read zero. Register index 0 is the command word, 1 the data word and 2 the status word. Index 3 reads zero.
- R3: A command write with the launch bit set loads status bit 0 (done) with 1. It loads status bit 1 (error) with 1 exactly when the access is unsupported. Any function code other than 1, 2, 7, 8, 9 or 11 is unsupported. A command write with launch clear leaves status unchanged.
- R4: A launch is unsupported whenever dcc is non-zero, position is non-zero, or site is 2 or 3.
- R5: Function 1 on site 0 reads or writes main-board oscillator `device` for devices 0 to 5. A write stores the current data word. Device 6 and above are unsupported.
- R6: Function 1 on site 1 reads or writes daughter-board oscillator `device` for devices below DB_OSC_DEPTH. Devices at or above that depth are unsupported.
- R7: A read of function 2 returns 3300000 for site 0, device 0, and entry `device` of DB_VOLT_VAL for site 1 with a device below DB_VOLT_DEPTH. Every other function 2 access, including any write, is unsupported.
- R8: A write of function 8 to site 0, device 0 makes `shutdown_req` high for exactly the one cycle after the command write. Function 9 does the same on `reboot_req`. Any other form of these functions is unsupported and raises no pulse.
- R9: A write of function 7 or 11 to site 0, device 0 is supported and changes no oscillator and no output. Reads of these functions and other sites or devices are unsupported.
- R10: A supported read loads its result into the data word. An unsupported read leaves the data word unchanged.
- R11: A direct write to the status word keeps only bits 1:0, and the upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index: 0 command, 1 data, 2 status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |
| shutdown_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
The assertions watch every cycle for these properties:
- Command read-back never shows the launch bit or the reserved bits.
- Every launch leaves the done flag set.
- A launch with a non-zero dcc, a non-zero position or site 2 or 3 leaves both status flags set.
- A rejected read of that kind leaves the data word unchanged.
- The request pulses last one cycle, never occur together, and never rise without a launch in the previous cycle.

Only the bench's sweeps can show the rest. They go over every function code, site and low device index in both directions. They check the decode of the supported set, the oscillator reset values, and that writes reach the correct entry and no other. They also check the returned voltage values.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;

  localparam int REG_W  = 32;
  localparam int MB_OSC = 6;

  typedef struct packed {
    logic        launch;
    logic        is_wr;
    logic [3:0]  dcc;
    logic [5:0]  fcode;
    logic [1:0]  rsvd;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cmd_word_t;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [5:0] FC_OSC   = 6'd1;
  localparam logic [5:0] FC_VOLT  = 6'd2;
  localparam logic [5:0] FC_VMUX  = 6'd7;
  localparam logic [5:0] FC_POFF  = 6'd8;
  localparam logic [5:0] FC_RBOOT = 6'd9;
  localparam logic [5:0] FC_DMODE = 6'd11;

  localparam logic [31:0] MB_VOLT_UV   = 32'd3300000;
  localparam logic [31:0] CMD_KEEP_MSK = 32'h7FF3_FFFF;

  function automatic logic [31:0] mb_osc_reset(input int idx);
    case (idx)
      0:       return 32'd50000000;
      1:       return 32'd23750000;
      default: return 32'd24000000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_cmd_pkg::*;
#(
  parameter int DB_OSC_DEPTH  = 2,
  parameter int DB_VOLT_DEPTH = 2,
  parameter logic [DB_VOLT_DEPTH*32-1:0] DB_VOLT_VAL = {32'd1000000, 32'd900000},
  localparam int NOSC = MB_OSC + DB_OSC_DEPTH,
  localparam int IDXW = (NOSC > 1) ? $clog2(NOSC) : 1
) (
  input  cmd_word_t         cmd,
  output logic              acc_ok,
  output logic              osc_hit,
  output logic [IDXW-1:0]   osc_idx,
  output logic [REG_W-1:0]  volt_val,
  output logic              poff_hit,
  output logic              rboot_hit
);

  logic base_ok;
  logic on_mb;
  logic on_db;
  logic dev0;
  logic [REG_W-1:0] db_volt;

  assign base_ok = (cmd.dcc == 4'd0) && (cmd.pos == 4'd0) && !cmd.site[1];
  assign on_mb   = (cmd.site == 2'd0);
  assign on_db   = (cmd.site == 2'd1);
  assign dev0    = (cmd.dev == 12'd0);

  always_comb begin
    db_volt = '0;
    for (int k = 0; k < DB_VOLT_DEPTH; k++) begin
      if (cmd.dev == 12'(k)) db_volt = DB_VOLT_VAL[k*32 +: 32];
    end
  end

  always_comb begin
    acc_ok    = 1'b0;
    osc_hit   = 1'b0;
    osc_idx   = '0;
    volt_val  = '0;
    poff_hit  = 1'b0;
    rboot_hit = 1'b0;
    if (base_ok) begin
      case (cmd.fcode)
        FC_OSC: begin
          if (on_mb && (cmd.dev < 12'(MB_OSC))) begin
            acc_ok  = 1'b1;
            osc_hit = 1'b1;
            osc_idx = IDXW'(cmd.dev);
          end else if (on_db && (cmd.dev < 12'(DB_OSC_DEPTH))) begin
            acc_ok  = 1'b1;
            osc_hit = 1'b1;
            osc_idx = IDXW'(MB_OSC) + IDXW'(cmd.dev);
          end
        end
        FC_VOLT: begin
          if (!cmd.is_wr) begin
            if (on_db && (cmd.dev < 12'(DB_VOLT_DEPTH))) begin
              acc_ok   = 1'b1;
              volt_val = db_volt;
            end else if (on_mb && dev0) begin
              acc_ok   = 1'b1;
              volt_val = MB_VOLT_UV;
            end
          end
        end
        FC_VMUX, FC_DMODE: begin
          acc_ok = cmd.is_wr && on_mb && dev0;
        end
        FC_POFF: begin
          acc_ok   = cmd.is_wr && on_mb && dev0;
          poff_hit = cmd.is_wr && on_mb && dev0;
        end
        FC_RBOOT: begin
          acc_ok    = cmd.is_wr && on_mb && dev0;
          rboot_hit = cmd.is_wr && on_mb && dev0;
        end
        default: acc_ok = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank
  import cfg_cmd_pkg::*;
#(
  parameter int DB_OSC_DEPTH = 2,
  parameter logic [DB_OSC_DEPTH*32-1:0] DB_OSC_INIT = {32'd45000000, 32'd60000000},
  localparam int NOSC = MB_OSC + DB_OSC_DEPTH,
  localparam int IDXW = (NOSC > 1) ? $clog2(NOSC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDXW-1:0]   idx,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata
);

  logic [REG_W-1:0] osc_q [NOSC];

  for (genvar i = 0; i < NOSC; i++) begin : g_osc
    localparam logic [REG_W-1:0] RST_VAL =
      (i < MB_OSC) ? mb_osc_reset(i) : DB_OSC_INIT[((i >= MB_OSC) ? (i - MB_OSC) : 0)*32 +: 32];
    logic ent_en;
    assign ent_en = we && (idx == IDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      osc_q[i] <= RST_VAL;
      else if (ent_en) osc_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NOSC; k++) begin
      if (idx == IDXW'(k)) rdata = osc_q[k];
    end
  end

endmodule

// File: rtl/cfg_cmd_ctrl.sv
module cfg_cmd_ctrl
  import cfg_cmd_pkg::*;
#(
  parameter int DB_OSC_DEPTH  = 2,
  parameter logic [DB_OSC_DEPTH*32-1:0]  DB_OSC_INIT = {32'd45000000, 32'd60000000},
  parameter int DB_VOLT_DEPTH = 2,
  parameter logic [DB_VOLT_DEPTH*32-1:0] DB_VOLT_VAL = {32'd1000000, 32'd900000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        shutdown_req,
  output logic        reboot_req
);

  localparam int NOSC = MB_OSC + DB_OSC_DEPTH;
  localparam int IDXW = (NOSC > 1) ? $clog2(NOSC) : 1;

  cmd_word_t        wcmd;
  logic             cmd_wr;
  logic             launch;
  logic             acc_ok;
  logic             osc_hit;
  logic [IDXW-1:0]  osc_idx;
  logic [REG_W-1:0] volt_val;
  logic [REG_W-1:0] osc_rdata;
  logic             poff_hit;
  logic             rboot_hit;
  logic             osc_we;
  logic [REG_W-1:0] rd_result;

  logic [REG_W-1:0] cmd_q,  cmd_d;
  logic [REG_W-1:0] data_q, data_d;
  logic [1:0]       stat_q, stat_d;
  logic             poff_q, poff_d;
  logic             rboot_q, rboot_d;
  logic             cmd_en, data_en, stat_en;

  assign wcmd   = cmd_word_t'(wr_data);
  assign cmd_wr = wr_en && (reg_sel == SEL_CMD);
  assign launch = cmd_wr && wcmd.launch;

  cfg_cmd_decode #(
    .DB_OSC_DEPTH  (DB_OSC_DEPTH),
    .DB_VOLT_DEPTH (DB_VOLT_DEPTH),
    .DB_VOLT_VAL   (DB_VOLT_VAL)
  ) u_decode (
    .cmd       (wcmd),
    .acc_ok    (acc_ok),
    .osc_hit   (osc_hit),
    .osc_idx   (osc_idx),
    .volt_val  (volt_val),
    .poff_hit  (poff_hit),
    .rboot_hit (rboot_hit)
  );

  assign osc_we = launch && acc_ok && wcmd.is_wr && osc_hit;

  cfg_osc_bank #(
    .DB_OSC_DEPTH (DB_OSC_DEPTH),
    .DB_OSC_INIT  (DB_OSC_INIT)
  ) u_osc (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (osc_we),
    .idx   (osc_idx),
    .wdata (data_q),
    .rdata (osc_rdata)
  );

  assign rd_result = osc_hit ? osc_rdata : volt_val;

  // next-state logic
  always_comb begin
    cmd_en  = cmd_wr;
    cmd_d   = wr_data & CMD_KEEP_MSK;
    data_en = 1'b0;
    data_d  = data_q;
    stat_en = 1'b0;
    stat_d  = stat_q;
    if (wr_en && (reg_sel == SEL_DATA)) begin
      data_en = 1'b1;
      data_d  = wr_data;
    end else if (launch && !wcmd.is_wr && acc_ok) begin
      data_en = 1'b1;
      data_d  = rd_result;
    end
    if (wr_en && (reg_sel == SEL_STAT)) begin
      stat_en = 1'b1;
      stat_d  = wr_data[1:0];
    end else if (launch) begin
      stat_en = 1'b1;
      stat_d  = {~acc_ok, 1'b1};
    end
    poff_d  = launch && acc_ok && poff_hit;
    rboot_d = launch && acc_ok && rboot_hit;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      data_q  <= '0;
      stat_q  <= '0;
      poff_q  <= 1'b0;
      rboot_q <= 1'b0;
    end else begin
      if (cmd_en)  cmd_q  <= cmd_d;
      if (data_en) data_q <= data_d;
      if (stat_en) stat_q <= stat_d;
      poff_q  <= poff_d;
      rboot_q <= rboot_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CMD:  rd_data = cmd_q;
      SEL_DATA: rd_data = data_q;
      SEL_STAT: rd_data = {30'd0, stat_q};
      default:  rd_data = '0;
    endcase
  end

  assign shutdown_req = poff_q;
  assign reboot_req   = rboot_q;

endmodule

// File: rtl/cfg_cmd_ctrl_chk.sv
module cfg_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  reg_sel,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        shutdown_req,
  input logic        reboot_req,
  input logic [1:0]  stat_q,
  input logic [31:0] data_q
);

  logic launch;
  logic bad_frame;
  assign launch    = wr_en && (reg_sel == 2'd0) && wr_data[31];
  assign bad_frame = (wr_data[29:26] != 4'd0) || (wr_data[15:12] != 4'd0) || wr_data[17];

  // R2
  p_cmd_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (rd_data[31] == 1'b0 && rd_data[19:18] == 2'b00));

  // R3
  p_launch_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> stat_q[0]);

  // R4
  p_bad_frame_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && bad_frame) |=> (stat_q == 2'b11));

  // R10
  p_bad_read_keeps_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !wr_data[30] && bad_frame) |=> $stable(data_q));

  // R8
  p_poff_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  p_rboot_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);

  p_req_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));

  p_poff_from_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_req) |-> $past(launch && wr_data[30]));

  p_rboot_from_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reboot_req) |-> $past(launch && wr_data[30]));

  // R11
  p_stat_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> (rd_data[31:2] == 30'd0));

endmodule

bind cfg_cmd_ctrl cfg_cmd_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .reg_sel      (reg_sel),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .shutdown_req (shutdown_req),
  .reboot_req   (reboot_req),
  .stat_q       (stat_q),
  .data_q       (data_q)
);

// File: tb/cfg_cmd_ctrl_tb_top.sv
module cfg_cmd_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  reg_sel;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        shutdown_req;
  logic        reboot_req;

  int checks;
  int errors;
  logic seen_sd, seen_rb;
  logic [31:0] m_osc [8];

  cfg_cmd_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .reg_sel      (reg_sel),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .shutdown_req (shutdown_req),
    .reboot_req   (reboot_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_sel = s; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    seen_sd = shutdown_req;
    seen_rb = reboot_req;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s; wr_en = 1'b0;
    #1 v = rd_data;
  endtask

  function automatic string tag_of(input int fn, input int site, input int dcc, input int pos);
    if (dcc != 0 || pos != 0 || site > 1) return "R4";
    if (fn == 1) return (site == 0) ? "R5" : "R6";
    if (fn == 2) return "R7";
    if (fn == 8 || fn == 9) return "R8";
    if (fn == 7 || fn == 11) return "R9";
    return "R3";
  endfunction

  // bench model of supported accesses
  task automatic model(input bit wr, input int fn, input int site, input int dev,
                       input int dcc, input int pos, output bit ok, output logic [31:0] val);
    ok = 1'b0; val = '0;
    if (dcc == 0 && pos == 0 && site < 2) begin
      case (fn)
        1: begin
          if (site == 0 && dev < 6) begin ok = 1'b1; val = m_osc[dev]; end
          if (site == 1 && dev < 2) begin ok = 1'b1; val = m_osc[6 + dev]; end
        end
        2: if (!wr) begin
          if (site == 0 && dev == 0) begin ok = 1'b1; val = 32'd3300000; end
          if (site == 1 && dev == 0) begin ok = 1'b1; val = 32'd900000; end
          if (site == 1 && dev == 1) begin ok = 1'b1; val = 32'd1000000; end
        end
        7, 8, 9, 11: ok = wr && site == 0 && dev == 0;
        default: ok = 1'b0;
      endcase
    end
  endtask

  task automatic do_cmd(input bit wr, input int fn, input int site, input int dev,
                        input int dcc, input int pos, input logic [31:0] opnd);
    logic [31:0] word, st, d_before, d_after, exp_val;
    bit ok;
    string tg;
    tg = tag_of(fn, site, dcc, pos);
    model(wr, fn, site, dev, dcc, pos, ok, exp_val);
    if (wr) bus_write(2'd1, opnd);
    bus_read(2'd1, d_before);
    word = {1'b1, wr, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
    bus_write(2'd0, word);
    check({tg, " poweroff pulse"}, {31'd0, seen_sd}, {31'd0, ok && wr && fn == 8});
    check({tg, " reboot pulse"},   {31'd0, seen_rb}, {31'd0, ok && wr && fn == 9});
    bus_read(2'd2, st);
    check({tg, " status"}, st, {30'd0, ~ok, 1'b1});
    check("R8 pulse ended", {30'd0, shutdown_req, reboot_req}, 32'd0);
    if (!wr) begin
      bus_read(2'd1, d_after);
      check("R10 data after read", d_after, ok ? exp_val : d_before);
    end else if (ok && fn == 1) begin
      m_osc[(site == 0) ? dev : 6 + dev] = opnd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    checks = 0; errors = 0;
    wr_en = 1'b0; reg_sel = 2'd0; wr_data = '0;
    m_osc[0] = 32'd50000000; m_osc[1] = 32'd23750000;
    for (int i = 2; i < 6; i++) m_osc[i] = 32'd24000000;
    m_osc[6] = 32'd60000000; m_osc[7] = 32'd45000000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      bus_read(2'(s), v);
      check("R1 reset register", v, 32'd0);
    end
    check("R1 reset requests", {30'd0, shutdown_req, reboot_req}, 32'd0);

    // R2 command storage, R3 no launch keeps status
    bus_write(2'd0, 32'hFFFF_FFFF & ~32'h8000_0000);
    bus_read(2'd0, v);
    check("R2 command readback", v, 32'h7FF3_FFFF);
    bus_read(2'd2, v);
    check("R3 status without launch", v, 32'd0);
    bus_write(2'd0, 32'h0000_0000);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, v);
    check("R2 unused index", v, 32'd0);

    // R11 status direct write
    bus_write(2'd2, 32'hFFFF_FFFE);
    bus_read(2'd2, v);
    check("R11 status low bits", v, 32'd2);
    bus_write(2'd2, 32'h0000_0001);
    bus_read(2'd2, v);
    check("R11 status low bits", v, 32'd1);

    // read sweep: reset values and decode (R1 R5 R6 R7 R9)
    for (int fn = 0; fn < 16; fn++)
      for (int site = 0; site < 4; site++)
        for (int dev = 0; dev < 8; dev++)
          do_cmd(1'b0, fn, site, dev, 0, 0, 32'd0);

    // R4 rejected frames on otherwise valid targets
    for (int d = 1; d < 16; d++) do_cmd(1'b0, 1, 0, 0, d, 0, 32'd0);
    for (int p = 1; p < 16; p++) do_cmd(1'b0, 1, 1, 0, 0, p, 32'd0);
    do_cmd(1'b1, 1, 0, 0, 3, 0, 32'hDEAD_0001);
    do_cmd(1'b1, 8, 0, 0, 0, 2, 32'hDEAD_0002);

    // write sweep (R5 R6 R7 R8 R9)
    for (int fn = 0; fn < 16; fn++)
      for (int site = 0; site < 4; site++)
        for (int dev = 0; dev < 8; dev++)
          do_cmd(1'b1, fn, site, dev, 0, 0, 32'hA500_0000 + 32'(fn * 256 + site * 16 + dev));

    // read back every oscillator (R5 R6)
    for (int dev = 0; dev < 8; dev++) begin
      do_cmd(1'b0, 1, 0, dev, 0, 0, 32'd0);
      do_cmd(1'b0, 1, 1, dev, 0, 0, 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule